// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block provides four banks of sixteen general-purpose pins behind a 16-bit register read/write port. Each bank holds its own direction, output-value, peripheral-handover, per-pin interrupt mask, trigger-mode, edge-select and level-select registers. It also has a read-only synchronised pin view and a latched interrupt-status register. Pin inputs cross into the clock domain through a two-flop synchroniser. A further register stage holds the previous sample, so an edge is found by comparing two consecutive synchronised values.

A small aggregator at the top merges the four per-bank pending flags with six non-GPIO interrupt inputs into one 10-bit summary word. The non-GPIO inputs come from other blocks on the chip. The aggregator drives a single level-sensitive interrupt line to the host. The host services a bank by reading its status register and writing zero to it. For both-edge behaviour, the host flips a pin's edge-select bit after each event. Such a flip must never create an event by itself.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every per-pin mask register reads 0xFFFF. Every other writable register reads 0. The summary word reads 0, `irq` is low and `pin_oe` is all zero.
- R2: `pin_oe` follows the direction register (1 = output). `pin_out` drives the output-value bit, except where the handover bit is 1; there it drives the matching `alt_in` bit.
- R3: The pin view register (index 2) shows `pin_in` two clock edges after it changes, and not after one.
- R4: With trigger-mode bit 1 (edge), edge-select 1 latches a status bit on a rising transition and 0 on a falling one. The opposite transition latches nothing.
- R5: With trigger-mode bit 0 (level), level-select 1 latches while the pin is high and 0 while it is low. A clear while the level is still active leaves the bit set.
- R6: A pin whose mask bit is 1 never sets its status bit.
- R7: Writing 0 to a bank status register (index 8) clears all of that bank's status bits. Writing any non-zero value leaves them unchanged.
- R8: Changing the edge-select bit of a pin whose level is stable sets no status bit.
- R9: Summary word bits 0 to 3 are set while banks 0 to 3 hold any status bit. Bit 4+k is set when non-GPIO input k, registered once, is high and its enable bit 4+k (summary slot, index 1) is 1.
- R10: `irq` is high exactly when the global enable (summary slot, index 2, bit 0) is 1 and the summary word is non-zero.
- R11: `reg_addr[6:4]` selects bank 0..3 or the summary slot (4), and `reg_addr[3:0]` picks the register. Bank indices are 0 direction, 1 output value, 2 pin view, 3 handover, 4 mask, 5 trigger mode, 6 edge select, 7 level select and 8 status. Summary indices are 0 summary word, 1 enable, 2 global. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 7 | Register address: slot in [6:4], register index in [3:0] |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pin_in | input | 64 | Pad input levels, bank b pin p at bit 16*b+p |
| alt_in | input | 64 | Peripheral drive values used under handover |
| ext_irq | input | 6 | Non-GPIO interrupt requests |
| pin_out | output | 64 | Pad output values |
| pin_oe | output | 64 | Pad output enables |
| irq | output | 1 | Level interrupt to the host |

## Verification
Four properties are checked on every cycle. A masked pin's status bit never rises. A zero write with all pins in edge mode and no sample change leaves the bank clear. A set non-GPIO summary bit always traces back to its input one cycle earlier. The interrupt line stays low while the global enable is off. The directed scenarios cover the remaining behaviour. These are the two-cycle synchroniser latency, each edge and level polarity, and the level bit re-setting after a clear. They also cover non-zero status writes being ignored, edge-select flips on a steady pin, the handover mux and the address decode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [3:0] {
        RG_DIR   = 4'd0,
        RG_OUT   = 4'd1,
        RG_PIN   = 4'd2,
        RG_ALT   = 4'd3,
        RG_MASK  = 4'd4,
        RG_TRIG  = 4'd5,
        RG_EDGE  = 4'd6,
        RG_LEVEL = 4'd7,
        RG_STAT  = 4'd8
    } bank_reg_e;

    typedef enum logic [3:0] {
        TG_SUMMARY = 4'd0,
        TG_ENABLE  = 4'd1,
        TG_GLOBAL  = 4'd2
    } top_reg_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_irq_pkg::*;
#(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [3:0]      reg_idx,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] rdata,
    input  logic [PINS-1:0] pin_in,
    input  logic [PINS-1:0] alt_in,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic            pending
);
    logic [PINS-1:0] dir_q, out_q, alt_q, mask_q, trig_q, edge_q, level_q, stat_q;
    logic [PINS-1:0] smp, prev_q;
    logic [PINS-1:0] rise, fall, edge_hit, lvl_hit, evt;
    logic            clr;

    gpio_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (smp)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= smp;
    end

    // detection compares consecutive samples, so polarity writes alone never fire
    always_comb begin
        rise     = smp & ~prev_q;
        fall     = ~smp & prev_q;
        edge_hit = (edge_q & rise) | (~edge_q & fall);
        lvl_hit  = ~(smp ^ level_q);
        evt      = (trig_q & edge_hit) | (~trig_q & lvl_hit);
        clr      = wr_en && (reg_idx == RG_STAT) && (wdata == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            out_q   <= '0;
            alt_q   <= '0;
            mask_q  <= '1;
            trig_q  <= '0;
            edge_q  <= '0;
            level_q <= '0;
        end else if (wr_en) begin
            case (reg_idx)
                RG_DIR:   dir_q   <= wdata;
                RG_OUT:   out_q   <= wdata;
                RG_ALT:   alt_q   <= wdata;
                RG_MASK:  mask_q  <= wdata;
                RG_TRIG:  trig_q  <= wdata;
                RG_EDGE:  edge_q  <= wdata;
                RG_LEVEL: level_q <= wdata;
                default:  ;
            endcase
        end
    end

    // new events win over a same-cycle clear, so an active level re-latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (clr ? '0 : stat_q) | (evt & ~mask_q);
    end

    always_comb begin
        case (reg_idx)
            RG_DIR:   rdata = dir_q;
            RG_OUT:   rdata = out_q;
            RG_PIN:   rdata = smp;
            RG_ALT:   rdata = alt_q;
            RG_MASK:  rdata = mask_q;
            RG_TRIG:  rdata = trig_q;
            RG_EDGE:  rdata = edge_q;
            RG_LEVEL: rdata = level_q;
            RG_STAT:  rdata = stat_q;
            default:  rdata = '0;
        endcase
    end

    assign pin_out = (alt_q & alt_in) | (~alt_q & out_q);
    assign pin_oe  = dir_q;
    assign pending = |stat_q;

    // R6: a pin masked in the previous cycle cannot newly set its status bit
    p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));

    // R7: a zero write with every pin in edge mode and no sample change empties the bank
    p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (trig_q == '1) && (smp == prev_q)) |=> (stat_q == '0));
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int NUM_EXT   = 6,
    parameter int DATA_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [3:0]           reg_idx,
    input  logic                 wr_glb,
    input  logic [NUM_EXT-1:0]   wr_en_bits,
    output logic [DATA_W-1:0]    rdata,
    input  logic [NUM_BANKS-1:0] bank_pend,
    input  logic [NUM_EXT-1:0]   ext_irq,
    output logic                 irq
);
    localparam int TOP_W = NUM_BANKS + NUM_EXT;

    logic [NUM_EXT-1:0] en_q, ext_q;
    logic               glb_q;
    logic [TOP_W-1:0]   summary;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            glb_q <= 1'b0;
            ext_q <= '0;
        end else begin
            ext_q <= ext_irq;
            if (wr_en && reg_idx == TG_ENABLE) en_q  <= wr_en_bits;
            if (wr_en && reg_idx == TG_GLOBAL) glb_q <= wr_glb;
        end
    end

    assign summary = {ext_q & en_q, bank_pend};
    assign irq     = glb_q & (|summary);

    always_comb begin
        rdata = '0;
        case (reg_idx)
            TG_SUMMARY: rdata[TOP_W-1:0] = summary;
            TG_ENABLE:  rdata[NUM_BANKS +: NUM_EXT] = en_q;
            TG_GLOBAL:  rdata[0] = glb_q;
            default:    ;
        endcase
    end

    // R10: global enable off keeps the host line low
    p_global_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_q |-> !irq);

    // R9: a set non-GPIO summary bit had its input high one cycle earlier
    p_ext_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((summary[TOP_W-1:NUM_BANKS] & ~$past(ext_irq)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
    parameter int NUM_BANKS = 4,
    parameter int PINS      = 16,
    parameter int NUM_EXT   = 6,
    parameter int ADDR_W    = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic [PINS-1:0]           reg_wdata,
    output logic [PINS-1:0]           reg_rdata,
    input  logic [NUM_BANKS*PINS-1:0] pin_in,
    input  logic [NUM_BANKS*PINS-1:0] alt_in,
    input  logic [NUM_EXT-1:0]        ext_irq,
    output logic [NUM_BANKS*PINS-1:0] pin_out,
    output logic [NUM_BANKS*PINS-1:0] pin_oe,
    output logic                      irq
);
    localparam int SLOT_W   = ADDR_W - 4;
    localparam int TOP_SLOT = NUM_BANKS;

    logic [SLOT_W-1:0]    slot;
    logic [3:0]           idx;
    logic [PINS-1:0]      bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_pend;
    logic [PINS-1:0]      agg_rd;

    assign slot = reg_addr[ADDR_W-1:4];
    assign idx  = reg_addr[3:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.PINS(PINS)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr && (slot == SLOT_W'(b))),
            .reg_idx (idx),
            .wdata   (reg_wdata),
            .rdata   (bank_rd[b]),
            .pin_in  (pin_in[b*PINS +: PINS]),
            .alt_in  (alt_in[b*PINS +: PINS]),
            .pin_out (pin_out[b*PINS +: PINS]),
            .pin_oe  (pin_oe[b*PINS +: PINS]),
            .pending (bank_pend[b])
        );
    end

    gpio_irq_agg #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_EXT   (NUM_EXT),
        .DATA_W    (PINS)
    ) u_agg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr && (slot == SLOT_W'(TOP_SLOT))),
        .reg_idx    (idx),
        .wr_glb     (reg_wdata[0]),
        .wr_en_bits (reg_wdata[NUM_BANKS +: NUM_EXT]),
        .rdata      (agg_rd),
        .bank_pend  (bank_pend),
        .ext_irq    (ext_irq),
        .irq        (irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (slot == SLOT_W'(b)) reg_rdata = bank_rd[b];
        if (slot == SLOT_W'(TOP_SLOT)) reg_rdata = agg_rd;
    end
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] alt_in = '0;
    logic [5:0]  ext_irq = '0;
    logic [63:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .alt_in(alt_in), .ext_irq(ext_irq), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] s, input logic [3:0] i, input logic [15:0] d);
        reg_addr  = {s, i};
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, input logic [3:0] i, output logic [15:0] d);
        reg_addr = {s, i};
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(3'd0, 4'd4, d);  chk("R1 mask reset", d, 16'hFFFF);
        rd(3'd3, 4'd4, d);  chk("R1 mask reset bank3", d, 16'hFFFF);
        rd(3'd1, 4'd0, d);  chk("R1 dir reset", d, 16'h0);
        rd(3'd4, 4'd0, d);  chk("R1 summary reset", d, 16'h0);
        chk("R1 irq reset", irq, 0);
        chk("R1 oe reset", pin_oe, 64'h0);
        rd(3'd5, 4'd0, d);  chk("R11 unmapped slot", d, 16'h0);
        rd(3'd0, 4'd9, d);  chk("R11 unmapped index", d, 16'h0);
    endtask

    task automatic t_io;
        wr(3'd1, 4'd0, 16'h00F0);
        wr(3'd1, 4'd1, 16'h00A0);
        chk("R2 oe", pin_oe[31:16], 16'h00F0);
        chk("R2 out", pin_out[31:16], 16'h00A0);
        wr(3'd1, 4'd3, 16'h0080);
        #1 chk("R2 handover low", pin_out[31:16], 16'h0020);
        alt_in[23] = 1'b1;
        #1 chk("R2 handover high", pin_out[31:16], 16'h00A0);
    endtask

    task automatic t_pin_view;
        logic [15:0] d;
        pin_in[35:32] = 4'b0101;
        ticks(1);
        rd(3'd2, 4'd2, d); chk("R3 one edge", d, 16'h0);
        ticks(1);
        rd(3'd2, 4'd2, d); chk("R3 two edges", d, 16'h0005);
        pin_in[35:32] = 4'b0000;
        ticks(3);
    endtask

    task automatic t_edge;
        logic [15:0] d;
        wr(3'd4, 4'd2, 16'h0001);          // global enable
        wr(3'd0, 4'd5, 16'h0008);          // pin3 edge mode
        wr(3'd0, 4'd6, 16'h0008);          // rising
        wr(3'd0, 4'd4, 16'hFFF7);          // unmask pin3
        pin_in[3] = 1'b1;
        ticks(4);
        rd(3'd0, 4'd8, d); chk("R4 rising", d, 16'h0008);
        rd(3'd4, 4'd0, d); chk("R9 bank0 pending", d, 16'h0001);
        chk("R10 irq on", irq, 1);
        wr(3'd0, 4'd8, 16'h0000);
        rd(3'd0, 4'd8, d); chk("R7 clear", d, 16'h0);
        chk("R10 irq off", irq, 0);
        wr(3'd0, 4'd6, 16'h0000);          // falling
        pin_in[3] = 1'b0;
        ticks(4);
        rd(3'd0, 4'd8, d); chk("R4 falling", d, 16'h0008);
        wr(3'd0, 4'd8, 16'h0000);
    endtask

    task automatic t_flip;
        logic [15:0] d;
        pin_in[3] = 1'b1;                  // rising while falling selected
        ticks(4);
        rd(3'd0, 4'd8, d); chk("R4 wrong edge", d, 16'h0);
        wr(3'd0, 4'd6, 16'h0008);
        ticks(3);
        rd(3'd0, 4'd8, d); chk("R8 flip to rising", d, 16'h0);
        wr(3'd0, 4'd6, 16'h0000);
        ticks(3);
        rd(3'd0, 4'd8, d); chk("R8 flip to falling", d, 16'h0);
        pin_in[3] = 1'b0;
        ticks(4);
        rd(3'd0, 4'd8, d); chk("R8 real edge after flips", d, 16'h0008);
        wr(3'd0, 4'd8, 16'h0000);
    endtask

    task automatic t_level;
        logic [15:0] d;
        wr(3'd3, 4'd7, 16'h0001);          // pin0 high-active
        wr(3'd3, 4'd4, 16'hFFFE);
        ticks(4);
        rd(3'd3, 4'd8, d); chk("R5 idle low", d, 16'h0);
        pin_in[48] = 1'b1;
        ticks(4);
        rd(3'd3, 4'd8, d); chk("R5 high level", d, 16'h0001);
        rd(3'd4, 4'd0, d); chk("R9 bank3 pending", d, 16'h0008);
        wr(3'd3, 4'd8, 16'h0000);
        rd(3'd3, 4'd8, d); chk("R5 re-set after clear", d, 16'h0001);
        pin_in[48] = 1'b0;
        ticks(4);
        wr(3'd3, 4'd8, 16'h0000);
        rd(3'd3, 4'd8, d); chk("R5 cleared after release", d, 16'h0);
        wr(3'd3, 4'd7, 16'h0000);          // low-active, pin is low
        ticks(2);
        rd(3'd3, 4'd8, d); chk("R5 low level", d, 16'h0001);
        wr(3'd3, 4'd4, 16'hFFFF);
        wr(3'd3, 4'd8, 16'h0000);
        rd(3'd3, 4'd8, d); chk("R6 masked low level stays clear", d, 16'h0);
    endtask

    task automatic t_mask;
        logic [15:0] d;
        wr(3'd2, 4'd5, 16'h0020);
        wr(3'd2, 4'd6, 16'h0020);
        pin_in[37] = 1'b1;
        ticks(4);
        rd(3'd2, 4'd8, d); chk("R6 masked edge", d, 16'h0);
        chk("R6 irq quiet", irq, 0);
        pin_in[37] = 1'b0;
        ticks(3);
    endtask

    task automatic t_nonzero_write;
        logic [15:0] d;
        wr(3'd0, 4'd6, 16'h0008);
        pin_in[3] = 1'b1;
        ticks(4);
        wr(3'd0, 4'd8, 16'h0001);
        ticks(1);
        rd(3'd0, 4'd8, d); chk("R7 nonzero write ignored", d, 16'h0008);
        wr(3'd0, 4'd8, 16'h0000);
        rd(3'd0, 4'd8, d); chk("R7 zero write clears", d, 16'h0);
        pin_in[3] = 1'b0;
        ticks(3);
        wr(3'd0, 4'd4, 16'hFFFF);
    endtask

    task automatic t_ext;
        logic [15:0] d;
        ext_irq[2] = 1'b1;
        ticks(2);
        rd(3'd4, 4'd0, d); chk("R9 ext disabled", d, 16'h0);
        chk("R10 no source", irq, 0);
        wr(3'd4, 4'd1, 16'h0040);
        rd(3'd4, 4'd0, d); chk("R9 ext enabled", d, 16'h0040);
        chk("R10 ext irq", irq, 1);
        ext_irq = 6'h3F;
        wr(3'd4, 4'd1, 16'h03F0);
        ticks(1);
        rd(3'd4, 4'd0, d); chk("R9 all ext", d, 16'h03F0);
        wr(3'd4, 4'd2, 16'h0000);
        chk("R10 global off", irq, 0);
        rd(3'd4, 4'd0, d); chk("R10 summary kept", d, 16'h03F0);
        wr(3'd4, 4'd2, 16'h0001);
        chk("R10 global on", irq, 1);
        ext_irq = '0;
        ticks(2);
        chk("R9 ext released", irq, 0);
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
        t_reset();
        t_io();
        t_pin_view();
        t_edge();
        t_flip();
        t_level();
        t_mask();
        t_nonzero_write();
        t_ext();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule